// File: doc/BRIEF.md
# Power-Controller I2C Register Slave

This block is a two-wire serial slave that owns a single 8-bit control and status byte for a supply regulator. A host writes the upper six bits to set the regulator's modes. A read returns those six bits together with two diagnostic flags, over-temperature and overload, which other logic drives into the block. SCL and SDA arrive as raw pad levels and are oversampled on the system clock. SDA is driven back as an open-drain pull-down request.

The slave answers one 7-bit address. Its five upper bits are fixed at 00010, and the two lower bits come from a 2-bit select input, so four of these blocks can share one bus. A supply-good input gates the whole interface. While supply-good is low, the control bits are forced to zero and the slave never pulls SDA, so the regulator stays off until the supply has settled.

Top module: `pwr_ctl_i2c_reg`

## Requirements
- R1: A transfer begins only with a start condition (SDA falling while SCL is high). A stop condition (SDA rising while SCL is high) returns the slave to idle with SDA released.
- R2: The slave answers only the address {00010, addr_sel} sent MSB first, followed by the R/W bit (1 = read). For any other address it gives no acknowledge and ignores the rest of the bus activity until the next start condition.
- R3: The slave acknowledges a matched address byte and every write data byte by pulling SDA low during the ninth clock. It changes SDA only while SCL is low.
- R4: A write data byte sets ctrl_bits[5:0] to data bits 7:2. Data bits 1:0 are ignored.
- R5: Each further data byte in the same write transfer is acknowledged and overwrites ctrl_bits.
- R6: A read returns the byte {ctrl_bits[5:0], flag_hot, flag_over} MSB first. flag_hot sits in bit 1 and flag_over in bit 0, and both are taken as they stand when the byte starts.
- R7: During a read, an acknowledge from the master (SDA low on the ninth clock) makes the slave send the byte again. A missing acknowledge ends the read and releases SDA.
- R8: While supply_ok is low, ctrl_bits is held at zero and the slave does not pull SDA for any transfer.
- R9: After reset, ctrl_bits is zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | High when the supply is above its lockout threshold |
| addr_sel | input | 2 | Low two bits of the slave address |
| scl_in | input | 1 | Raw SCL level from the bus |
| sda_in | input | 1 | Raw SDA level from the bus |
| flag_hot | input | 1 | Over-temperature flag, returned in read bit 1 |
| flag_over | input | 1 | Overload flag, returned in read bit 0 |
| ctrl_bits | output | 6 | Writable control bits, register bits 7:2 |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The condition hardest to reach from the ports is a read that the master keeps acknowledging. The slave must restart its byte on the falling edge that closes the master's acknowledge clock, so the bench acknowledges the first read byte, checks the second byte bit for bit, and only then sends no acknowledge before the stop. The supply lockout is exercised with a complete, correctly addressed write sent while supply_ok is low. The bench checks that this write draws no acknowledge and leaves the control bits at zero, and then checks that the same write succeeds once supply_ok returns.

// File: rtl/pwr_ctl_i2c_reg.sv
`timescale 1ns/1ps
module pwr_ctl_i2c_reg #(
  parameter logic [4:0] ADDR_HI = 5'b00010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic [1:0] addr_sel,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       flag_hot,
  input  logic       flag_over,
  output logic [5:0] ctrl_bits,
  output logic       sda_drive_low
);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  st_t        state;
  logic [7:0] shreg;
  logic [2:0] cnt;
  logic       full, rw, mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end
  end

  wire scl_q    = scl_sy[1];
  wire sda_q    = sda_sy[1];
  wire scl_rise = scl_q & ~scl_d;
  wire scl_fall = ~scl_q & scl_d;
  wire start_c  = scl_q & scl_d & sda_d & ~sda_q;
  wire stop_c   = scl_q & scl_d & ~sda_d & sda_q;
  wire [7:0] snapshot = {ctrl_bits, flag_hot, flag_over};
  wire addr_hit = (shreg[7:1] == {ADDR_HI, addr_sel});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      shreg         <= '0;
      cnt           <= '0;
      full          <= 1'b0;
      rw            <= 1'b0;
      mack          <= 1'b0;
      ctrl_bits     <= '0;
      sda_drive_low <= 1'b0;
    end else if (!supply_ok) begin
      state         <= ST_IDLE;
      full          <= 1'b0;
      ctrl_bits     <= '0;
      sda_drive_low <= 1'b0;
    end else if (start_c) begin
      state         <= ST_ADDR;
      cnt           <= '0;
      full          <= 1'b0;
      sda_drive_low <= 1'b0;
    end else if (stop_c) begin
      state         <= ST_IDLE;
      full          <= 1'b0;
      sda_drive_low <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_q};
            cnt   <= cnt + 3'd1;
            if (cnt == 3'd7) full <= 1'b1;
          end else if (scl_fall && full) begin
            full <= 1'b0;
            cnt  <= '0;
            if (state == ST_ADDR) begin
              if (addr_hit) begin
                state         <= ST_AACK;
                rw            <= shreg[0];
                sda_drive_low <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              ctrl_bits     <= shreg[7:2];
              state         <= ST_WACK;
              sda_drive_low <= 1'b1;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              state         <= ST_RD;
              shreg         <= snapshot;
              sda_drive_low <= ~snapshot[7];
            end else begin
              state         <= ST_WR;
              sda_drive_low <= 1'b0;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            state         <= ST_WR;
            sda_drive_low <= 1'b0;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) full <= 1'b1;
          end else if (scl_fall) begin
            if (full) begin
              full          <= 1'b0;
              sda_drive_low <= 1'b0;
              state         <= ST_RACK;
            end else begin
              shreg         <= {shreg[6:0], 1'b0};
              sda_drive_low <= ~shreg[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_q;
          end else if (scl_fall) begin
            if (mack) begin
              state         <= ST_RD;
              cnt           <= '0;
              shreg         <= snapshot;
              sda_drive_low <= ~snapshot[7];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pwr_ctl_i2c_reg_chk.sv
`timescale 1ns/1ps
module pwr_ctl_i2c_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic [5:0] ctrl_bits,
  input logic       sda_drive_low,
  input logic       scl_s,
  input logic [2:0] st
);

  // R8
  lockout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (ctrl_bits == 6'd0));

  // R8
  lockout_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !sda_drive_low);

  // R3
  pull_on_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_s);

  // R4
  ctrl_on_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ctrl_bits) && $past(supply_ok)) |-> !scl_s);

  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive_low |-> (st != 3'd0));

endmodule

bind pwr_ctl_i2c_reg pwr_ctl_i2c_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ctrl_bits(ctrl_bits),
  .sda_drive_low(sda_drive_low), .scl_s(scl_q), .st(state)
);

// File: tb/sim_pwr_ctl_i2c_reg.sv
`timescale 1ns/1ps
module sim_pwr_ctl_i2c_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b1;
  logic [1:0] addr_sel = 2'd0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       flag_hot = 1'b0;
  logic       flag_over = 1'b0;
  logic [5:0] ctrl_bits;
  logic       sda_drive_low;
  wire        sda_bus = sda_m & ~sda_drive_low;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_ctl_i2c_reg u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .addr_sel(addr_sel),
    .scl_in(scl), .sda_in(sda_bus), .flag_hot(flag_hot), .flag_over(flag_over),
    .ctrl_bits(ctrl_bits), .sda_drive_low(sda_drive_low)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic b, output logic s);
    sda_m = b;
    wait_clk(15);
    scl = 1'b1;
    wait_clk(10);
    s = sda_bus;
    wait_clk(10);
    scl = 1'b0;
    wait_clk(5);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1;
    scl = 1'b1;
    wait_clk(10);
    sda_m = 1'b0;
    wait_clk(10);
    scl = 1'b0;
    wait_clk(5);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0;
    wait_clk(10);
    scl = 1'b1;
    wait_clk(10);
    sda_m = 1'b1;
    wait_clk(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      d[i] = s;
    end
    bit_cycle(~give_ack, s);
  endtask

  task automatic t_reset();
    check(ctrl_bits == 6'd0, "R9 ctrl after reset", ctrl_bits, 0);
    check(!sda_drive_low, "R9 sda released after reset", sda_drive_low, 0);
  endtask

  task automatic t_write_basic();
    logic a;
    addr_sel = 2'd0;
    i2c_start();
    send_byte(8'h10, a);
    check(a, "R3 address ack sel0", a, 1);
    send_byte(8'hB7, a);
    check(a, "R3 data ack", a, 1);
    i2c_stop();
    check(ctrl_bits == 6'h2D, "R4 ctrl from bits 7:2, low bits ignored", ctrl_bits, 6'h2D);
    check(!sda_drive_low, "R1 sda released after stop", sda_drive_low, 0);
  endtask

  task automatic t_read_flags();
    logic a;
    logic [7:0] d;
    flag_hot = 1'b1;
    flag_over = 1'b0;
    i2c_start();
    send_byte(8'h11, a);
    check(a, "R2 read address ack", a, 1);
    recv_byte(1'b0, d);
    i2c_stop();
    check(d == 8'hB6, "R6 read value with hot flag", d, 8'hB6);
    flag_hot = 1'b0;
    flag_over = 1'b1;
    i2c_start();
    send_byte(8'h11, a);
    recv_byte(1'b0, d);
    i2c_stop();
    check(d == 8'hB5, "R6 read value with overload flag", d, 8'hB5);
    flag_over = 1'b0;
  endtask

  task automatic t_mismatch();
    logic a;
    addr_sel = 2'd2;
    i2c_start();
    send_byte(8'h10, a);
    check(!a, "R2 no ack on wrong address", a, 0);
    send_byte(8'h00, a);
    check(!a, "R2 following byte ignored", a, 0);
    i2c_stop();
    check(ctrl_bits == 6'h2D, "R2 ctrl unchanged after mismatch", ctrl_bits, 6'h2D);
  endtask

  task automatic t_sel3_read_twice();
    logic a;
    logic [7:0] d1, d2;
    addr_sel = 2'd3;
    i2c_start();
    send_byte(8'h16, a);
    check(a, "R2 address ack sel3", a, 1);
    send_byte(8'hFC, a);
    i2c_stop();
    check(ctrl_bits == 6'h3F, "R4 ctrl all ones", ctrl_bits, 6'h3F);
    i2c_start();
    send_byte(8'h17, a);
    recv_byte(1'b1, d1);
    recv_byte(1'b0, d2);
    check(!sda_drive_low, "R7 sda released after nack", sda_drive_low, 0);
    i2c_stop();
    check(d1 == 8'hFC, "R6 first read byte", d1, 8'hFC);
    check(d2 == 8'hFC, "R7 second byte after master ack", d2, 8'hFC);
  endtask

  task automatic t_multi_write();
    logic a1, a2;
    addr_sel = 2'd1;
    i2c_start();
    send_byte(8'h12, a1);
    send_byte(8'h40, a1);
    check(ctrl_bits == 6'h10, "R5 first data byte", ctrl_bits, 6'h10);
    send_byte(8'h87, a2);
    i2c_stop();
    check(a1 && a2, "R5 both data bytes acked", {a1, a2}, 3);
    check(ctrl_bits == 6'h21, "R5 second byte overwrites", ctrl_bits, 6'h21);
  endtask

  task automatic t_supply();
    logic a;
    supply_ok = 1'b0;
    wait_clk(4);
    check(ctrl_bits == 6'd0, "R8 ctrl cleared at lockout", ctrl_bits, 0);
    i2c_start();
    send_byte(8'h12, a);
    check(!a, "R8 no ack during lockout", a, 0);
    send_byte(8'hFC, a);
    i2c_stop();
    check(ctrl_bits == 6'd0, "R8 write ignored during lockout", ctrl_bits, 0);
    supply_ok = 1'b1;
    wait_clk(4);
    i2c_start();
    send_byte(8'h12, a);
    check(a, "R8 ack after supply returns", a, 1);
    send_byte(8'h54, a);
    i2c_stop();
    check(ctrl_bits == 6'h15, "R8 write after supply returns", ctrl_bits, 6'h15);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_write_basic();
    t_read_flags();
    t_mismatch();
    t_sel3_read_twice();
    t_multi_write();
    t_supply();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule